// File: doc/BRIEF.md
# Unlock-Gated Control Register Window

This block sits between a CPU I/O port of four byte-wide offsets and a downstream synthesizer. Normally every access is passed straight through to the synthesizer. Writing the byte 0xFF to offset 2 unlocks a hidden window. While it is unlocked, offsets 2 and 3 no longer reach the synthesizer. Instead they act as an index/data pair into a bank of 25 mixer and configuration bytes. Writing 0xFE to offset 2 closes the window again. Offsets 0 and 1 are always forwarded.

The bank has a nonvolatile shadow copy of the same size. A write to index 0 is a command: it can restore the whole shadow into the live bank, or save the live bank into the shadow, in a single clock. A read of index 0 returns an identification byte that reports whether the surround option is fitted.

The block turns the live volume and tone bytes into signed decibel values and signed gains for the mixing datapath. It does not do the mixing arithmetic itself.

Top module: `ctlwin_gate`

## Requirements
- R1: Reset behaviour. After reset the window is locked and the index is 0. All live bytes are 0. The shadow holds 0x13 at index 0x13, 0x30 at index 0x14, 0x71 at index 0x15, and 0 at every other index.
- R2: Opening and closing. A write of 0xFF to offset 2 unlocks the window from the next cycle, and a write of 0xFE to offset 2 locks it. Neither write is forwarded (ds_wr stays low). A read of offset 3 after locking is forwarded again.
- R3: Always-forwarded offsets. Writes and reads of offsets 0 and 1 are forwarded in both modes. While locked, offsets 2 and 3 are also forwarded, with the same offset and data.
- R4: Index and data protocol. While unlocked, a write to offset 2 loads the index and a write to offset 3 stores the data byte at the indexed register (indices 1 to 0x18). Neither write is forwarded. A read of offset 3 returns the indexed byte.
- R5: Status read. While unlocked, a read of offset 2 returns status_in and is not forwarded.
- R6: Out-of-range index. A write at an index of 0x19 or above changes no live byte and no shadow byte. A read at such an index returns 0xFF.
- R7: Identification byte. A read at index 0 returns 0x50 when the SURROUND parameter is 1 and 0x70 when it is 0.
- R8: Save and restore. A write to index 0 with bit 0 set copies all 25 shadow bytes into the live bank. A write with bit 1 set and bit 0 clear copies the live bank into the shadow. When both bits are set, only the restore takes place and the shadow is left unchanged.
- R9: Master volume decode. The master volume codes are bits 5:0 of index 4 (left) and index 5 (right). A code c of 0x1C or above gives master_db = 2c−120 dB, so 0x3F gives +6 dB and 0x1C gives −64 dB. Lower codes assert the mute output, and master_db is then 0.
- R10: Tone decode. The bass code is bits 3:0 of index 6 and the treble code is bits 3:0 of index 7. Each gives 3·(code−6) dB, so code 6 is flat. The bass value is clamped to the range −12 to +15 dB and the treble value to the range −12 to +12 dB.
- R11: FM and sample gains. Index 9 is FM left, 0x0A is FM right, 0x0B is sample left and 0x0C is sample right. Each byte is in offset binary, and its signed gain is the byte value minus 128.
- R12: Forwarded read data. When a read is forwarded, cpu_rdata equals ds_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_ofs | input | 2 | CPU port offset |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational |
| status_in | input | 8 | Status byte returned at offset 2 while unlocked |
| ds_wr | output | 1 | Forwarded write strobe to the synthesizer |
| ds_rd | output | 1 | Forwarded read strobe to the synthesizer |
| ds_ofs | output | 2 | Forwarded offset |
| ds_wdata | output | 8 | Forwarded write data |
| ds_rdata | input | 8 | Read data from the synthesizer |
| master_db_l | output | 8 | Signed master gain in dB, left |
| master_db_r | output | 8 | Signed master gain in dB, right |
| master_mute_l | output | 1 | Master mute, left |
| master_mute_r | output | 1 | Master mute, right |
| bass_db | output | 8 | Signed bass gain in dB |
| treble_db | output | 8 | Signed treble gain in dB |
| fm_gain_l | output | 8 | Signed FM gain, left |
| fm_gain_r | output | 8 | Signed FM gain, right |
| smp_gain_l | output | 8 | Signed sample gain, left |
| smp_gain_r | output | 8 | Signed sample gain, right |

## Verification
Read data and the forwarded strobes are combinational. The bench therefore samples them one nanosecond after it drives the strobe, inside the same cycle. The lock state, the index, the bank contents and the decoded outputs change at the rising edge that ends a write cycle. The bench samples them at the falling edge that follows. Every bank effect is observed through a later read of offset 3, so each check lands one edge after the write that caused it.

// File: rtl/ctlwin_pkg.sv
package ctlwin_pkg;

  localparam logic [1:0] OFS_INDEX = 2'd2;
  localparam logic [1:0] OFS_DATA  = 2'd3;
  localparam logic [7:0] ESC_OPEN  = 8'hFF;
  localparam logic [7:0] ESC_CLOSE = 8'hFE;

  localparam int unsigned IDX_CMD    = 0;
  localparam int unsigned IDX_MVOL_L = 4;
  localparam int unsigned IDX_MVOL_R = 5;
  localparam int unsigned IDX_BASS   = 6;
  localparam int unsigned IDX_TREBLE = 7;
  localparam int unsigned IDX_FM_L   = 9;
  localparam int unsigned IDX_FM_R   = 10;
  localparam int unsigned IDX_SMP_L  = 11;
  localparam int unsigned IDX_SMP_R  = 12;

  localparam int unsigned MVOL_FLOOR = 28;

  // Routing decisions for one CPU access
  typedef struct packed {
    logic bank_wr;
    logic wr_fwd;
    logic rd_fwd;
    logic sel_status;
    logic sel_bank;
  } route_t;

  function automatic logic [7:0] shadow_init(input int unsigned i);
    case (i)
      19: return 8'h13;
      20: return 8'h30;
      21: return 8'h71;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic mvol_mute(input logic [5:0] c);
    return int'(c) < MVOL_FLOOR;
  endfunction

  function automatic logic [7:0] mvol_db(input logic [5:0] c);
    int v;
    if (int'(c) < MVOL_FLOOR) v = 0;
    else v = 2 * int'(c) - 120;
    return 8'(v);
  endfunction

  function automatic logic [7:0] tone_db(input logic [3:0] c, input int max_db);
    int v;
    v = 3 * (int'(c) - 6);
    if (v < -12) v = -12;
    if (v > max_db) v = max_db;
    return 8'(v);
  endfunction

  function automatic logic [7:0] offset_gain(input logic [7:0] b);
    return {~b[7], b[6:0]};
  endfunction

endpackage

// File: rtl/ctlwin_port.sv
module ctlwin_port
  import ctlwin_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_wr,
  input  logic       cpu_rd,
  input  logic [1:0] cpu_ofs,
  input  logic [7:0] cpu_wdata,
  output logic       ctl_mode,
  output logic [7:0] cur_idx,
  output route_t     route
);

  logic at_index, at_data, is_esc, open_ev, close_ev, idx_wr;

  assign at_index = (cpu_ofs == OFS_INDEX);
  assign at_data  = (cpu_ofs == OFS_DATA);
  assign is_esc   = at_index && (cpu_wdata == ESC_OPEN || cpu_wdata == ESC_CLOSE);
  assign open_ev  = cpu_wr && at_index && (cpu_wdata == ESC_OPEN);
  assign close_ev = cpu_wr && at_index && (cpu_wdata == ESC_CLOSE);
  assign idx_wr   = cpu_wr && at_index && ctl_mode && !is_esc;

  always_comb begin
    route.bank_wr    = cpu_wr && at_data && ctl_mode;
    route.wr_fwd     = cpu_wr && !(cpu_ofs[1] && (ctl_mode || is_esc));
    route.rd_fwd     = cpu_rd && !(cpu_ofs[1] && ctl_mode);
    route.sel_status = ctl_mode && at_index;
    route.sel_bank   = ctl_mode && at_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_mode <= 1'b0;
      cur_idx  <= 8'h00;
    end else begin
      if (open_ev)       ctl_mode <= 1'b1;
      else if (close_ev) ctl_mode <= 1'b0;
      if (idx_wr) cur_idx <= cpu_wdata;
    end
  end

endmodule

// File: rtl/ctlwin_bank.sv
module ctlwin_bank
  import ctlwin_pkg::*;
#(
  parameter int unsigned NREGS    = 25,
  parameter bit          SURROUND = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bank_wr,
  input  logic [7:0]         idx,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  output logic [NREGS*8-1:0] live_flat,
  output logic [NREGS*8-1:0] shadow_flat
);

  localparam logic [7:0] ID_BYTE = SURROUND ? 8'h50 : 8'h70;

  logic [7:0] live   [NREGS];
  logic [7:0] shadow [NREGS];
  logic       cmd_wr, do_restore, do_save, idx_ok;

  assign idx_ok     = int'(idx) < int'(NREGS);
  assign cmd_wr     = bank_wr && (idx == 8'(IDX_CMD));
  assign do_restore = cmd_wr && wdata[0];
  assign do_save    = cmd_wr && wdata[1] && !wdata[0];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live[i]   <= 8'h00;
        shadow[i] <= shadow_init(i);
      end else begin
        if (do_restore)
          live[i] <= shadow[i];
        else if (bank_wr && i != IDX_CMD && idx == 8'(i))
          live[i] <= wdata;
        if (do_save)
          shadow[i] <= live[i];
      end
    end
    assign live_flat[i*8 +: 8]   = live[i];
    assign shadow_flat[i*8 +: 8] = shadow[i];
  end

  always_comb begin
    rdata = 8'hFF;
    if (idx == 8'(IDX_CMD)) rdata = ID_BYTE;
    else if (idx_ok) begin
      for (int i = 1; i < int'(NREGS); i++)
        if (idx == 8'(i)) rdata = live[i];
    end
  end

endmodule

// File: rtl/ctlwin_decode.sv
module ctlwin_decode
  import ctlwin_pkg::*;
(
  input  logic [5:0] mvol_l,
  input  logic [5:0] mvol_r,
  input  logic [3:0] bass_code,
  input  logic [3:0] treble_code,
  input  logic [7:0] fm_l,
  input  logic [7:0] fm_r,
  input  logic [7:0] smp_l,
  input  logic [7:0] smp_r,
  output logic [7:0] master_db_l,
  output logic [7:0] master_db_r,
  output logic       master_mute_l,
  output logic       master_mute_r,
  output logic [7:0] bass_db,
  output logic [7:0] treble_db,
  output logic [7:0] fm_gain_l,
  output logic [7:0] fm_gain_r,
  output logic [7:0] smp_gain_l,
  output logic [7:0] smp_gain_r
);

  assign master_db_l   = mvol_db(mvol_l);
  assign master_db_r   = mvol_db(mvol_r);
  assign master_mute_l = mvol_mute(mvol_l);
  assign master_mute_r = mvol_mute(mvol_r);
  assign bass_db       = tone_db(bass_code, 15);
  assign treble_db     = tone_db(treble_code, 12);
  assign fm_gain_l     = offset_gain(fm_l);
  assign fm_gain_r     = offset_gain(fm_r);
  assign smp_gain_l    = offset_gain(smp_l);
  assign smp_gain_r    = offset_gain(smp_r);

endmodule

// File: rtl/ctlwin_gate.sv
module ctlwin_gate
  import ctlwin_pkg::*;
#(
  parameter int unsigned NREGS    = 25,
  parameter bit          SURROUND = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_wr,
  input  logic       cpu_rd,
  input  logic [1:0] cpu_ofs,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  input  logic [7:0] status_in,
  output logic       ds_wr,
  output logic       ds_rd,
  output logic [1:0] ds_ofs,
  output logic [7:0] ds_wdata,
  input  logic [7:0] ds_rdata,
  output logic [7:0] master_db_l,
  output logic [7:0] master_db_r,
  output logic       master_mute_l,
  output logic       master_mute_r,
  output logic [7:0] bass_db,
  output logic [7:0] treble_db,
  output logic [7:0] fm_gain_l,
  output logic [7:0] fm_gain_r,
  output logic [7:0] smp_gain_l,
  output logic [7:0] smp_gain_r
);

  localparam int unsigned FLAT_W = NREGS * 8;

  logic              ctl_mode;
  logic [7:0]        cur_idx;
  route_t            route;
  logic [7:0]        bank_rdata;
  logic [FLAT_W-1:0] live_flat;
  logic [FLAT_W-1:0] shadow_flat;

  ctlwin_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_ofs   (cpu_ofs),
    .cpu_wdata (cpu_wdata),
    .ctl_mode  (ctl_mode),
    .cur_idx   (cur_idx),
    .route     (route)
  );

  ctlwin_bank #(.NREGS(NREGS), .SURROUND(SURROUND)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .bank_wr     (route.bank_wr),
    .idx         (cur_idx),
    .wdata       (cpu_wdata),
    .rdata       (bank_rdata),
    .live_flat   (live_flat),
    .shadow_flat (shadow_flat)
  );

  ctlwin_decode u_dec (
    .mvol_l        (live_flat[IDX_MVOL_L*8 +: 6]),
    .mvol_r        (live_flat[IDX_MVOL_R*8 +: 6]),
    .bass_code     (live_flat[IDX_BASS*8 +: 4]),
    .treble_code   (live_flat[IDX_TREBLE*8 +: 4]),
    .fm_l          (live_flat[IDX_FM_L*8 +: 8]),
    .fm_r          (live_flat[IDX_FM_R*8 +: 8]),
    .smp_l         (live_flat[IDX_SMP_L*8 +: 8]),
    .smp_r         (live_flat[IDX_SMP_R*8 +: 8]),
    .master_db_l   (master_db_l),
    .master_db_r   (master_db_r),
    .master_mute_l (master_mute_l),
    .master_mute_r (master_mute_r),
    .bass_db       (bass_db),
    .treble_db     (treble_db),
    .fm_gain_l     (fm_gain_l),
    .fm_gain_r     (fm_gain_r),
    .smp_gain_l    (smp_gain_l),
    .smp_gain_r    (smp_gain_r)
  );

  assign ds_wr    = route.wr_fwd;
  assign ds_rd    = route.rd_fwd;
  assign ds_ofs   = cpu_ofs;
  assign ds_wdata = cpu_wdata;

  always_comb begin
    if (route.sel_status)    cpu_rdata = status_in;
    else if (route.sel_bank) cpu_rdata = bank_rdata;
    else                     cpu_rdata = ds_rdata;
  end

endmodule

// File: rtl/ctlwin_gate_chk.sv
module ctlwin_gate_chk #(
  parameter int unsigned NREGS = 25
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_wr,
  input logic               cpu_rd,
  input logic [1:0]         cpu_ofs,
  input logic [7:0]         cpu_wdata,
  input logic [7:0]         cpu_rdata,
  input logic [7:0]         status_in,
  input logic               ds_wr,
  input logic               ds_rd,
  input logic               ctl_mode,
  input logic [7:0]         cur_idx,
  input logic [NREGS*8-1:0] live_flat,
  input logic [NREGS*8-1:0] shadow_flat,
  input logic               master_mute_l
);

  logic bank_hit;
  assign bank_hit = ctl_mode && cpu_wr && cpu_ofs == 2'd3;

  assert_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_ofs == 2'd2 && cpu_wdata == 8'hFF |=> ctl_mode);

  assert_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_ofs == 2'd2 && cpu_wdata == 8'hFE |=> !ctl_mode);

  assert_esc_hidden_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && cpu_ofs == 2'd2 && (cpu_wdata == 8'hFF || cpu_wdata == 8'hFE) |-> !ds_wr);

  assert_low_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_ofs[1] |-> ds_wr) and (cpu_rd && !cpu_ofs[1] |-> ds_rd));

  assert_ctl_nofwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_mode && cpu_wr && cpu_ofs[1] |-> !ds_wr);

  assert_status_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_mode && cpu_rd && cpu_ofs == 2'd2 |-> cpu_rdata == status_in && !ds_rd);

  assert_oor_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bank_hit && int'(cur_idx) >= int'(NREGS) |=> $stable(live_flat) && $stable(shadow_flat));

  assert_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bank_hit && cur_idx == 8'h00 && cpu_wdata[0]
    |=> live_flat == $past(shadow_flat) && $stable(shadow_flat));

  assert_mute_R9: assert property (@(posedge clk) disable iff (!rst_n)
    master_mute_l == (live_flat[4*8 +: 6] < 6'd28));

endmodule

bind ctlwin_gate ctlwin_gate_chk #(.NREGS(NREGS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_wr        (cpu_wr),
  .cpu_rd        (cpu_rd),
  .cpu_ofs       (cpu_ofs),
  .cpu_wdata     (cpu_wdata),
  .cpu_rdata     (cpu_rdata),
  .status_in     (status_in),
  .ds_wr         (ds_wr),
  .ds_rd         (ds_rd),
  .ctl_mode      (ctl_mode),
  .cur_idx       (cur_idx),
  .live_flat     (live_flat),
  .shadow_flat   (shadow_flat),
  .master_mute_l (master_mute_l)
);

// File: tb/ctlwin_gate_test.sv
module ctlwin_gate_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [1:0] cpu_ofs = 2'd0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] status_in = 8'h3C;
  logic [7:0] ds_rdata = 8'hA5;

  logic [7:0] cpu_rdata, ds_wdata, rdata_s;
  logic       ds_wr, ds_rd;
  logic [1:0] ds_ofs;
  logic [7:0] mdb_l, mdb_r, bass, treble, fm_l, fm_r, sm_l, sm_r;
  logic       mute_l, mute_r;

  logic [7:0] ds_wdata_s, mdb_l_s, mdb_r_s, bass_s, treble_s, fm_l_s, fm_r_s, sm_l_s, sm_r_s;
  logic       ds_wr_s, ds_rd_s, mute_l_s, mute_r_s;
  logic [1:0] ds_ofs_s;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  logic       seen_wr, seen_rd;
  logic [1:0] seen_ofs;
  logic [7:0] seen_wdata, rd_val, rd_val_s;

  always #5 clk = ~clk;

  ctlwin_gate uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_ofs(cpu_ofs),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .status_in(status_in),
    .ds_wr(ds_wr), .ds_rd(ds_rd), .ds_ofs(ds_ofs), .ds_wdata(ds_wdata), .ds_rdata(ds_rdata),
    .master_db_l(mdb_l), .master_db_r(mdb_r), .master_mute_l(mute_l), .master_mute_r(mute_r),
    .bass_db(bass), .treble_db(treble), .fm_gain_l(fm_l), .fm_gain_r(fm_r),
    .smp_gain_l(sm_l), .smp_gain_r(sm_r)
  );

  ctlwin_gate #(.SURROUND(1'b1)) uut_s (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_ofs(cpu_ofs),
    .cpu_wdata(cpu_wdata), .cpu_rdata(rdata_s), .status_in(status_in),
    .ds_wr(ds_wr_s), .ds_rd(ds_rd_s), .ds_ofs(ds_ofs_s), .ds_wdata(ds_wdata_s), .ds_rdata(ds_rdata),
    .master_db_l(mdb_l_s), .master_db_r(mdb_r_s), .master_mute_l(mute_l_s), .master_mute_r(mute_r_s),
    .bass_db(bass_s), .treble_db(treble_s), .fm_gain_l(fm_l_s), .fm_gain_r(fm_r_s),
    .smp_gain_l(sm_l_s), .smp_gain_r(sm_r_s)
  );

  // Vector fields: [22] read, [21:20] offset, [19:12] data, [11:4] expected, [3:0] requirement
  localparam int NV = 49;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 2'd3, 8'h00, 8'hA5, 4'd12}, // R12 locked read forwarded
    {1'b0, 2'd2, 8'hFF, 8'h00, 4'd2},  // R2 open
    {1'b1, 2'd2, 8'h00, 8'h3C, 4'd5},  // R5 status
    {1'b0, 2'd2, 8'h00, 8'h00, 4'd4},
    {1'b1, 2'd3, 8'h00, 8'h70, 4'd7},  // R7 id, no surround
    {1'b0, 2'd2, 8'h04, 8'h00, 4'd4},
    {1'b0, 2'd3, 8'h3F, 8'h00, 4'd4},
    {1'b1, 2'd3, 8'h00, 8'h3F, 4'd4},  // R4 readback
    {1'b0, 2'd2, 8'h19, 8'h00, 4'd6},
    {1'b0, 2'd3, 8'h55, 8'h00, 4'd6},
    {1'b1, 2'd3, 8'h00, 8'hFF, 4'd6},  // R6 out of range
    {1'b0, 2'd2, 8'h18, 8'h00, 4'd4},
    {1'b0, 2'd3, 8'hAA, 8'h00, 4'd4},
    {1'b1, 2'd3, 8'h00, 8'hAA, 4'd4},  // R4 last index
    {1'b0, 2'd2, 8'h13, 8'h00, 4'd1},
    {1'b1, 2'd3, 8'h00, 8'h00, 4'd1},  // R1 live reset zero
    {1'b0, 2'd2, 8'h00, 8'h00, 4'd8},
    {1'b0, 2'd3, 8'h01, 8'h00, 4'd8},  // R8 restore
    {1'b0, 2'd2, 8'h13, 8'h00, 4'd1},
    {1'b1, 2'd3, 8'h00, 8'h13, 4'd1},  // R1 shadow default
    {1'b0, 2'd2, 8'h14, 8'h00, 4'd1},
    {1'b1, 2'd3, 8'h00, 8'h30, 4'd1},
    {1'b0, 2'd2, 8'h15, 8'h00, 4'd1},
    {1'b1, 2'd3, 8'h00, 8'h71, 4'd1},
    {1'b0, 2'd2, 8'h04, 8'h00, 4'd8},
    {1'b1, 2'd3, 8'h00, 8'h00, 4'd8},  // R8 restore overwrote 0x3F
    {1'b0, 2'd2, 8'h07, 8'h00, 4'd8},
    {1'b0, 2'd3, 8'h9A, 8'h00, 4'd8},
    {1'b0, 2'd2, 8'h00, 8'h00, 4'd8},
    {1'b0, 2'd3, 8'h02, 8'h00, 4'd8},  // R8 save
    {1'b0, 2'd2, 8'h07, 8'h00, 4'd8},
    {1'b0, 2'd3, 8'h11, 8'h00, 4'd8},
    {1'b0, 2'd2, 8'h00, 8'h00, 4'd8},
    {1'b0, 2'd3, 8'h01, 8'h00, 4'd8},
    {1'b0, 2'd2, 8'h07, 8'h00, 4'd8},
    {1'b1, 2'd3, 8'h00, 8'h9A, 4'd8},  // R8 saved value came back
    {1'b0, 2'd3, 8'h22, 8'h00, 4'd8},
    {1'b0, 2'd2, 8'h00, 8'h00, 4'd8},
    {1'b0, 2'd3, 8'h03, 8'h00, 4'd8},  // R8 both bits
    {1'b0, 2'd2, 8'h07, 8'h00, 4'd8},
    {1'b1, 2'd3, 8'h00, 8'h9A, 4'd8},  // R8 restore wins
    {1'b0, 2'd3, 8'h44, 8'h00, 4'd8},
    {1'b0, 2'd2, 8'h00, 8'h00, 4'd8},
    {1'b0, 2'd3, 8'h01, 8'h00, 4'd8},
    {1'b0, 2'd2, 8'h07, 8'h00, 4'd8},
    {1'b1, 2'd3, 8'h00, 8'h9A, 4'd8},  // R8 shadow untouched by both bits
    {1'b0, 2'd2, 8'hFE, 8'h00, 4'd2},  // R2 close
    {1'b1, 2'd2, 8'h00, 8'hA5, 4'd2},  // R2 offset 2 forwarded again
    {1'b1, 2'd3, 8'h00, 8'hA5, 4'd12}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [1:0] ofs, input logic [7:0] d);
    @(negedge clk);
    cpu_ofs = ofs; cpu_wdata = d; cpu_wr = 1'b1;
    #1;
    seen_wr = ds_wr; seen_ofs = ds_ofs; seen_wdata = ds_wdata;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] ofs);
    @(negedge clk);
    cpu_ofs = ofs; cpu_rd = 1'b1;
    #1;
    rd_val = cpu_rdata; rd_val_s = rdata_s; seen_rd = ds_rd;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
    cpu_write(2'd2, idx);
    cpu_write(2'd3, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R0 act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state seen through ports
    chk("R1 mute after reset", {7'd0, mute_l}, 8'h01);
    chk("R1 fm gain after reset", fm_l, 8'h80);
    cpu_read(2'd2);
    chk("R1 locked: offset2 read forwarded", rd_val, 8'hA5);
    chk("R1 locked: ds_rd", {7'd0, seen_rd}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][22]) begin
        cpu_read(VEC[i][21:20]);
        chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), rd_val, VEC[i][11:4]);
      end else begin
        cpu_write(VEC[i][21:20], VEC[i][19:12]);
      end
    end

    // R3 locked pass-through of offset 2
    cpu_write(2'd2, 8'h12);
    chk("R3 locked ds_wr", {7'd0, seen_wr}, 8'h01);
    chk("R3 locked ds_ofs", {6'd0, seen_ofs}, 8'h02);
    chk("R3 locked ds_wdata", seen_wdata, 8'h12);
    // R2 escape not forwarded
    cpu_write(2'd2, 8'hFF);
    chk("R2 escape ds_wr", {7'd0, seen_wr}, 8'h00);
    // R3 offset 0 forwarded while unlocked
    cpu_write(2'd0, 8'h5B);
    chk("R3 unlocked offset0 ds_wr", {7'd0, seen_wr}, 8'h01);
    cpu_read(2'd1);
    chk("R3 unlocked offset1 read", rd_val, 8'hA5);
    // R4 data write not forwarded
    cpu_write(2'd2, 8'h04);
    chk("R4 index write ds_wr", {7'd0, seen_wr}, 8'h00);
    cpu_write(2'd3, 8'h3F);
    chk("R4 data write ds_wr", {7'd0, seen_wr}, 8'h00);
    // R5 status read not forwarded
    cpu_read(2'd2);
    chk("R5 status ds_rd", {7'd0, seen_rd}, 8'h00);
    // R7 surround id
    cpu_write(2'd2, 8'h00);
    cpu_read(2'd3);
    chk("R7 id with surround", rd_val_s, 8'h50);

    // R9 master volume
    chk("R9 code 3F", mdb_l, 8'd6);
    chk("R9 code 3F mute", {7'd0, mute_l}, 8'h00);
    reg_write(8'h05, 8'h1C);
    chk("R9 code 1C", mdb_r, 8'hC0);
    chk("R9 code 1C mute", {7'd0, mute_r}, 8'h00);
    reg_write(8'h05, 8'hDB);
    chk("R9 code 1B mute", {7'd0, mute_r}, 8'h01);
    // R10 tone
    reg_write(8'h06, 8'h06);
    chk("R10 bass flat", bass, 8'h00);
    reg_write(8'h06, 8'h00);
    chk("R10 bass low clamp", bass, 8'hF4);
    reg_write(8'h06, 8'h0F);
    chk("R10 bass high clamp", bass, 8'd15);
    reg_write(8'h07, 8'hFF);
    chk("R10 treble high clamp", treble, 8'd12);
    reg_write(8'h07, 8'h09);
    chk("R10 treble +9", treble, 8'd9);
    // R11 offset-binary gains
    reg_write(8'h09, 8'h80);
    chk("R11 fm left zero", fm_l, 8'h00);
    reg_write(8'h0A, 8'h00);
    chk("R11 fm right min", fm_r, 8'h80);
    reg_write(8'h0B, 8'hFF);
    chk("R11 sample left max", sm_l, 8'h7F);
    reg_write(8'h0C, 8'h90);
    chk("R11 sample right +16", sm_r, 8'h10);

    // R1 reset while unlocked clears mode and live bank
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cpu_read(2'd3);
    chk("R1 mode cleared by reset", rd_val, 8'hA5);
    chk("R1 live cleared by reset", sm_r, 8'h80);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule